// File: doc/BRIEF.md
# Memory Status Word Fetch Sequencer

This block sits in a memory controller next to a low-power DDR memory and, when the host asks for it, reads back the memory's status word. The status word holds identification and configuration data. A start request is accepted only while the memory reports that every bank is closed. The sequencer then sends a mode-register load whose bank code selects the status register. It waits a settling interval with only no-operation commands on the bus, and then issues a read with every address line at zero.

The memory answers with a two-beat burst. The sequencer keeps the first beat, drops the second, and raises `done` for one cycle together with the new word. It then holds the bus idle for a recovery interval before it releases `busy`, after which normal traffic may resume. The settling and recovery intervals are parameters counted in controller clock cycles. A start that arrives while the banks are not idle produces a one-cycle error pulse and no bus activity.

Commands are driven as a 3-bit code `{ras_n, cas_n, we_n}`. The bank address field selects the register target: 00 is the standard mode register, 01 the status register, 10 the extended mode register and 11 is reserved.

Top module: `srr_fetch`

## Requirements
- R1: While `rst` is high and on the cycle after it, `cmd_o` is NOP (3'b111), `ba_o` and `addr_o` are zero, and `busy_o`, `done_o`, `err_o` and `status_o` are all zero.
- R2: When `start_i` and `banks_idle_i` are high at an edge with the block idle, the next cycle carries a mode-register load (3'b000) with `ba_o` = 2'b01 and `addr_o` = 0.
- R3: When `start_i` is high at an edge with the block idle and `banks_idle_i` low, `err_o` is high for exactly the next cycle, `busy_o` stays low and no command other than NOP is issued.
- R4: After the mode-register load, exactly T_SRC-1 NOP cycles follow, so the READ appears exactly T_SRC cycles after the load.
- R5: The READ command (3'b101) is driven with `addr_o` = 0 and `ba_o` = 2'b00.
- R6: On the edge after the READ that first sees `rd_valid_i` high, `rd_data_i` is loaded into `status_o`, and `done_o` is high for that one following cycle only.
- R7: `status_o` changes only when `done_o` rises. The second burst beat, and any `rd_valid_i` pulse while the block is idle, leave it unchanged.
- R8: `busy_o` rises in the cycle of the mode-register load and stays high until T_SRR cycles after the cycle carrying the second beat. Only NOP is issued during the recovery interval.
- R9: A `start_i` that arrives while `busy_o` is high has no effect on the command bus.
- R10: While `busy_o` is low, `cmd_o` is NOP except in the cycle in which `busy_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request for a status fetch |
| banks_idle_i | input | 1 | All banks precharged and memory idle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse with a fresh status word |
| err_o | output | 1 | One-cycle pulse when a start is refused |
| cmd_o | output | 3 | Memory command {ras_n, cas_n, we_n} |
| ba_o | output | 2 | Bank address / register select |
| addr_o | output | ADDR_W | Memory address bus |
| rd_valid_i | input | 1 | Read data beat valid |
| rd_data_i | input | DATA_W | Read data beat |
| status_o | output | DATA_W | Last captured status word |

## Verification
Every output is registered, so each result is due on the first sample after the clock edge that sees its cause. The load follows start by one cycle and the READ follows the load by T_SRC cycles. `done_o` and the captured word follow the first valid beat by one cycle, and `busy_o` falls T_SRR cycles after the second beat. The bench drives inputs on falling edges and samples on the next falling edge, stepping cycle by cycle through each wait and checking the command on every cycle, so an early or late command shows up at its exact cycle. Parameters are set to T_SRC=3 and T_SRR=4 so that each wait spans several cycles.

// File: rtl/srr_fetch.sv
module srr_fetch #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32,
  parameter int T_SRC  = 2,
  parameter int T_SRR  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              banks_idle_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [2:0]        cmd_o,
  output logic [1:0]        ba_o,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              rd_valid_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] status_o
);
  localparam int MAXW  = (T_SRC > T_SRR) ? T_SRC : T_SRR;
  localparam int CNT_W = $clog2(MAXW + 1);
  localparam logic [2:0] CMD_NOP  = 3'b111;
  localparam logic [2:0] CMD_LMR  = 3'b000;
  localparam logic [2:0] CMD_READ = 3'b101;
  localparam logic [1:0] BA_STAT  = 2'b01;

  typedef enum logic [2:0] {S_IDLE, S_SRC, S_BEAT1, S_BEAT2, S_SRR} state_t;
  state_t state;
  logic [CNT_W-1:0] cnt;
  wire cnt_zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      cmd_o    <= CMD_NOP;
      ba_o     <= '0;
      addr_o   <= '0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      status_o <= '0;
    end else begin
      cmd_o  <= CMD_NOP;
      ba_o   <= '0;
      addr_o <= '0;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state)
        S_IDLE:
          if (start_i) begin
            if (banks_idle_i) begin
              cmd_o  <= CMD_LMR;
              ba_o   <= BA_STAT;
              busy_o <= 1'b1;
              cnt    <= CNT_W'(T_SRC - 1);
              state  <= S_SRC;
            end else begin
              err_o <= 1'b1;
            end
          end
        S_SRC:
          if (cnt_zero) begin
            cmd_o <= CMD_READ;
            state <= S_BEAT1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_BEAT1:
          if (rd_valid_i) begin
            status_o <= rd_data_i;
            done_o   <= 1'b1;
            state    <= S_BEAT2;
          end
        S_BEAT2:
          if (rd_valid_i) begin
            cnt   <= CNT_W'(T_SRR - 1);
            state <= S_SRR;
          end
        S_SRR:
          if (cnt_zero) begin
            busy_o <= 1'b0;
            state  <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srr_fetch_chk.sv
module srr_fetch_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic [2:0]        cmd_o,
  input logic [1:0]        ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] status_o
);
  // R2
  lmr_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'b000) |-> (ba_o == 2'b01 && addr_o == '0));
  // R5
  read_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'b101) |-> (ba_o == 2'b00 && addr_o == '0));
  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (!busy_o && cmd_o == 3'b111));
  // R10
  idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cmd_o == 3'b111));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (cmd_o == 3'b000));
  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(status_o));
endmodule

bind srr_fetch srr_fetch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
  .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .status_o(status_o)
);

// File: tb/srr_fetch_bench.sv
`timescale 1ns/1ps
module srr_fetch_bench;
  localparam int AW = 13;
  localparam int DW = 32;
  localparam int TSRC = 3;
  localparam int TSRR = 4;
  localparam logic [2:0] NOP = 3'b111, LMR = 3'b000, RD = 3'b101;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, bidle = 1'b1, rvalid = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic busy, done, err;
  logic [2:0] cmd;
  logic [1:0] ba;
  logic [AW-1:0] addr;
  logic [DW-1:0] status;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  srr_fetch #(.ADDR_W(AW), .DATA_W(DW), .T_SRC(TSRC), .T_SRR(TSRR)) u_srr_fetch (
    .clk(clk), .rst(rst), .start_i(start), .banks_idle_i(bidle),
    .busy_o(busy), .done_o(done), .err_o(err), .cmd_o(cmd), .ba_o(ba),
    .addr_o(addr), .rd_valid_i(rvalid), .rd_data_i(rdata), .status_o(status));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_state(input string req, input logic [DW-1:0] st);
    chk(cmd == NOP, req, cmd, NOP);
    chk(busy == 0 && done == 0 && err == 0, req, {busy, done, err}, 0);
    chk(ba == 0 && addr == 0, req, {ba, addr}, 0);
    chk(status == st, req, status, st);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    idle_state("R1", '0);
    rst = 1'b0;
    @(negedge clk);
    idle_state("R1", '0);
  endtask

  task automatic t_reject(input logic [DW-1:0] st);
    bidle = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; bidle = 1'b1;
    chk(err == 1'b1, "R3", err, 1);
    chk(busy == 1'b0 && cmd == NOP, "R3", {busy, cmd}, {1'b0, NOP});
    @(negedge clk);
    chk(err == 1'b0, "R3", err, 0);
    idle_state("R3", st);
  endtask

  task automatic t_stray(input logic [DW-1:0] st);
    rvalid = 1'b1; rdata = 32'hDEAD_0001;
    @(negedge clk);
    rdata = 32'hDEAD_0002;
    @(negedge clk);
    rvalid = 1'b0;
    chk(status == st && done == 0, "R7", status, st);
    @(negedge clk);
    idle_state("R7", st);
  endtask

  task automatic t_fetch(input logic [DW-1:0] d1, input logic [DW-1:0] d2, input int lat, input bit poke);
    start = 1'b1;
    @(negedge clk);
    start = poke;
    chk(cmd == LMR, "R2", cmd, LMR);
    chk(ba == 2'b01 && addr == 0, "R2", {ba, addr}, {2'b01, {AW{1'b0}}});
    chk(busy == 1'b1, "R8", busy, 1);
    for (int i = 1; i < TSRC; i++) begin
      @(negedge clk);
      chk(cmd == NOP, poke ? "R9" : "R4", cmd, NOP);
    end
    @(negedge clk);
    start = 1'b0;
    chk(cmd == RD, "R4", cmd, RD);
    chk(ba == 0 && addr == 0, "R5", {ba, addr}, 0);
    for (int i = 1; i < lat; i++) begin
      @(negedge clk);
      chk(done == 0 && cmd == NOP, "R6", {done, cmd}, {1'b0, NOP});
    end
    rvalid = 1'b1; rdata = d1;
    @(negedge clk);
    rdata = d2;
    chk(done == 1'b1, "R6", done, 1);
    chk(status == d1, "R6", status, d1);
    @(negedge clk);
    rvalid = 1'b0; rdata = '0;
    chk(done == 1'b0, "R6", done, 0);
    chk(status == d1, "R7", status, d1);
    chk(busy == 1'b1, "R8", busy, 1);
    for (int i = 1; i < TSRR; i++) begin
      @(negedge clk);
      chk(busy == 1'b1 && cmd == NOP, "R8", {busy, cmd}, {1'b1, NOP});
    end
    @(negedge clk);
    chk(busy == 1'b0, "R8", busy, 0);
    idle_state("R10", d1);
  endtask

  task automatic t_abort();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    idle_state("R1", '0);
  endtask

  initial begin
    t_reset();
    t_reject('0);
    t_fetch(32'h1234_5678, 32'hFFFF_0000, 1, 1'b0);
    t_stray(32'h1234_5678);
    t_fetch(32'hA5A5_0F0F, 32'h0000_0001, 4, 1'b1);
    t_reject(32'hA5A5_0F0F);
    t_fetch(32'h0000_0000, 32'h8888_8888, 2, 1'b0);
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule